// File: doc/BRIEF.md
# Reset Cause and Lockup Reset Controller

This block sits on a simple APB slave port and does two jobs for the system reset path. First, it merges three reset sources into one system reset request: a request from the processor, a request from the watchdog, and the processor's lockup status. The lockup source only counts when software has set an enable bit. Second, it keeps a record of which of those sources caused the most recent system reset, so boot code can find out why it is running again.

The record lives in flops that only power-on reset clears. The system reset that the block itself requests leaves them alone. Software clears a flag by writing 1 to it. The top 16 words of the 4 KB window hold read-only identification values, so software can check that the block is present before it uses it.

Top module: `sysctl_top`

## Requirements
- R1: After power-on reset (`por_ni` and `rst_ni` low), the cause register reads 0, the option register reads 0 and `sys_rst_req_o` is low.
- R2: While `cpu_rst_req_i` is high, the combined request is high. On the next clock edge, cause bit 0 becomes 1.
- R3: While `wdog_rst_req_i` is high, the combined request is high. On the next clock edge, cause bit 1 becomes 1.
- R4: When the lockup enable is 1 and `cpu_lockup_i` is high, the combined request is high. On the next clock edge, cause bit 2 becomes 1.
- R5: When the lockup enable is 0, `cpu_lockup_i` raises no request and sets no cause bit.
- R6: The option register is at byte offset 0x000. Bit 0 is the lockup enable. It reads back the value written, bits 31:1 read as zero, and it clears to 0 on `rst_ni`.
- R7: The cause register is at byte offset 0x004 and uses these bit positions: 0 for processor request, 1 for watchdog, 2 for lockup. Bits 31:3 read as zero. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a source sets a bit in the same cycle as a clear, the set wins.
- R8: Asserting `rst_ni` alone leaves the cause bits unchanged. Only `por_ni` clears them.
- R9: `sys_rst_req_o` is high for exactly one cycle when the combined request goes from low to high. The pulse is combinational in that cycle, and the output stays low while the combined request remains high.
- R10: The identification words read as follows: 0xFE0 returns `PART_NUM` (default 0x26, legal 0x26 to 0x29), 0xFE4 returns 0xB8, and 0xFC0 to 0xFCC return zero. Writes to this region have no effect.
- R11: Reads from any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, combinational from address |
| cpu_rst_req_i | input | 1 | Processor reset request |
| wdog_rst_req_i | input | 1 | Watchdog reset request |
| cpu_lockup_i | input | 1 | Processor lockup status level |
| sys_rst_req_o | output | 1 | Single-cycle system reset request |

## Verification
The reset request output depends combinationally on the inputs, so the bench checks it 1 ns after it drives the sources, within the same cycle. It checks again one cycle later to confirm that the pulse has ended. Cause bits and the option bit change on the clock edge that samples the source or the write access phase. The bench therefore reads them back through the APB port in a later access and never in the same cycle. Read data is sampled 1 ns into the access phase. The random phase drives all three sources every cycle. A bench model tracks the previous combined request and the accumulated flags, and that model gives both the expected pulse in each cycle and the final cause value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] OPT_IDX   = IW'(0);
  localparam logic [IW-1:0] CAUSE_IDX = IW'(1);
  localparam int CPU_BIT  = 0;
  localparam int WDOG_BIT = 1;
  localparam int LOCK_BIT = 2;
  localparam int NCAUSE   = 3;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/sysctl_rst_gen.sv
module sysctl_rst_gen
  import sysctl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cpu_req_i,
  input  logic   wdog_req_i,
  input  logic   lockup_i,
  input  logic   en_we_i,
  input  logic   en_wdata_i,
  output logic   en_o,
  output cause_t src_o,
  output logic   sys_rst_req_o
);
  logic en_q, req_q, req_d;

  always_comb begin
    src_o           = '0;
    src_o[CPU_BIT]  = cpu_req_i;
    src_o[WDOG_BIT] = wdog_req_i;
    src_o[LOCK_BIT] = lockup_i & en_q;
  end
  assign req_d         = |src_o;
  assign sys_rst_req_o = req_d & ~req_q;
  assign en_o          = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);
  // R5
  lockup_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !cpu_req_i && !wdog_req_i) |-> !sys_rst_req_o);
  // R6
  opt_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_o == $past(en_wdata_i)));
endmodule

// File: rtl/sysctl_rst_cause.sv
module sysctl_rst_cause
  import sysctl_pkg::*;
(
  input  logic   clk_i,
  input  logic   por_ni,
  input  cause_t src_i,
  input  logic   clr_we_i,
  input  cause_t clr_mask_i,
  output cause_t flags_o
);
  cause_t flags_q;

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~(clr_we_i ? clr_mask_i : '0)) | src_i;
  end
  assign flags_o = flags_q;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_chk
    // R2 R3 R4
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      src_i[i] |=> flags_o[i]);
    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (clr_we_i && clr_mask_i[i] && !src_i[i]) |=> !flags_o[i]);
  end
endmodule

// File: rtl/sysctl_id_rom.sv
module sysctl_id_rom #(
  parameter logic [7:0] PART_NUM = 8'h26,
  parameter logic [3:0] REV      = 4'h0
) (
  input  logic [3:0] idx_i,
  output logic [7:0] data_o
);
  always_comb begin
    unique case (idx_i)
      4'd4:    data_o = 8'h04;
      4'd8:    data_o = PART_NUM;
      4'd9:    data_o = 8'hB8;
      4'd10:   data_o = {REV, 4'hB};
      4'd12:   data_o = 8'h0D;
      4'd13:   data_o = 8'hF0;
      4'd14:   data_o = 8'h05;
      4'd15:   data_o = 8'hB1;
      default: data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
  import sysctl_pkg::*;
#(
  parameter logic [7:0] PART_NUM = 8'h26,
  parameter logic [3:0] REV      = 4'h0
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  input  logic          cpu_rst_req_i,
  input  logic          wdog_rst_req_i,
  input  logic          cpu_lockup_i,
  output logic          sys_rst_req_o
);
  logic [IW-1:0] idx;
  logic          wr, id_hit, en;
  logic [7:0]    id_data;
  cause_t        src, flags;

  assign idx    = paddr_i[AW-1:2];
  assign wr     = psel_i & penable_i & pwrite_i;
  assign id_hit = &idx[IW-1:4];

  sysctl_rst_gen u_gen (
    .clk_i, .rst_ni,
    .cpu_req_i     (cpu_rst_req_i),
    .wdog_req_i    (wdog_rst_req_i),
    .lockup_i      (cpu_lockup_i),
    .en_we_i       (wr && idx == OPT_IDX),
    .en_wdata_i    (pwdata_i[0]),
    .en_o          (en),
    .src_o         (src),
    .sys_rst_req_o
  );

  sysctl_rst_cause u_cause (
    .clk_i, .por_ni,
    .src_i      (src),
    .clr_we_i   (wr && idx == CAUSE_IDX),
    .clr_mask_i (pwdata_i[NCAUSE-1:0]),
    .flags_o    (flags)
  );

  sysctl_id_rom #(.PART_NUM(PART_NUM), .REV(REV)) u_id (
    .idx_i  (idx[3:0]),
    .data_o (id_data)
  );

  always_comb begin
    prdata_o = '0;
    if (idx == OPT_IDX)        prdata_o[0]        = en;
    else if (idx == CAUSE_IDX) prdata_o[NCAUSE-1:0] = flags;
    else if (id_hit)           prdata_o[7:0]      = id_data;
  end

  // R7
  cause_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (idx == CAUSE_IDX) |-> (prdata_o[DW-1:NCAUSE] == '0));
  // R1
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    $rose(por_ni) |-> (flags == '0));
endmodule

// File: tb/sysctl_top_tb.sv
module sysctl_top_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, por_n = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic cpu = 0, wdog = 0, lock = 0, req;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_top u_dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .cpu_rst_req_i(cpu), .wdog_rst_req_i(wdog), .cpu_lockup_i(lock),
    .sys_rst_req_o(req)
  );

  function automatic logic comb_req(logic c, logic w, logic l, logic e);
    return c | w | (l & e);
  endfunction
  function automatic logic [2:0] flag_src(logic c, logic w, logic l, logic e);
    return {l & e, w, c};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge clk) penable = 1;
    #1 d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic en;
    logic prev;
    logic [2:0] model;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    // R1
    #1 chk("R1 req", {31'b0, req}, 0);
    apb_rd(12'h004, rd); chk("R1 cause", rd, 0);
    apb_rd(12'h000, rd); chk("R1 option", rd, 0);
    // R6
    apb_wr(12'h000, 32'hFFFF_FFFF);
    apb_rd(12'h000, rd); chk("R6 readback", rd, 1);
    // R2 R9
    cpu = 1; #1 chk("R2 req", {31'b0, req}, 1);
    @(negedge clk); #1 chk("R9 pulse end", {31'b0, req}, 0);
    @(negedge clk) cpu = 0;
    apb_rd(12'h004, rd); chk("R2 cause", rd, 32'h1);
    // R8 system reset keeps flags, clears option
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    apb_rd(12'h004, rd); chk("R8 cause kept", rd, 32'h1);
    apb_rd(12'h000, rd); chk("R6 option reset", rd, 0);
    // R7
    apb_wr(12'h004, 32'h0);
    apb_rd(12'h004, rd); chk("R7 write0", rd, 32'h1);
    apb_wr(12'h004, 32'h1);
    apb_rd(12'h004, rd); chk("R7 w1c", rd, 0);
    // R5
    lock = 1; #1 chk("R5 req", {31'b0, req}, 0);
    repeat (2) @(negedge clk); lock = 0;
    apb_rd(12'h004, rd); chk("R5 cause", rd, 0);
    // R4
    apb_wr(12'h000, 32'h1);
    lock = 1; #1 chk("R4 req", {31'b0, req}, 1);
    @(negedge clk) lock = 0;
    apb_rd(12'h004, rd); chk("R4 cause", rd, 32'h4);
    apb_wr(12'h004, 32'h7);
    // R3
    wdog = 1; #1 chk("R3 req", {31'b0, req}, 1);
    @(negedge clk) wdog = 0;
    apb_rd(12'h004, rd); chk("R3 cause", rd, 32'h2);
    // R7 set wins over clear
    wdog = 1; apb_wr(12'h004, 32'h2); wdog = 0;
    apb_rd(12'h004, rd); chk("R7 set wins", rd, 32'h2);
    // R10 R11
    apb_rd(12'hFE0, rd);
    chk("R10 part range", {31'b0, (rd >= 32'h26 && rd <= 32'h29)}, 1);
    apb_rd(12'hFE4, rd); chk("R10 FE4", rd, 32'hB8);
    apb_rd(12'hFC0, rd); chk("R10 FC0", rd, 0);
    apb_wr(12'hFE4, 32'h0);
    apb_rd(12'hFE4, rd); chk("R10 readonly", rd, 32'hB8);
    apb_rd(12'h100, rd); chk("R11 unmapped", rd, 0);
    // R1 power-on clears flags
    por_n = 0; rst_n = 0; repeat (2) @(negedge clk); por_n = 1; rst_n = 1; @(negedge clk);
    apb_rd(12'h004, rd); chk("R1 por cause", rd, 0);
    // random phase, R2 R3 R4 R5 R9
    for (int k = 0; k < 4; k++) begin
      en = 1'($urandom);
      apb_wr(12'h000, {31'b0, en});
      prev = 0; model = 0;
      for (int i = 0; i < 200; i++) begin
        logic c;
        cpu = ($urandom % 8) == 0; wdog = ($urandom % 8) == 0; lock = ($urandom % 4) == 0;
        c = comb_req(cpu, wdog, lock, en);
        #1 chk("R9 random pulse", {31'b0, req}, {31'b0, c & ~prev});
        prev = c;
        model |= flag_src(cpu, wdog, lock, en);
        @(negedge clk);
      end
      cpu = 0; wdog = 0; lock = 0;
      @(negedge clk);
      apb_rd(12'h004, rd); chk("R7 random cause", rd, {29'b0, model});
      apb_wr(12'h004, 32'h7);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule